// File: doc/BRIEF.md
# Type-Keyed Resolution Table

This block is a small fully associative table that remembers the outcome of dynamic call resolution. Each entry is keyed by two values taken together: the program counter of the call site and the runtime type identifier of the receiving object. The entry holds a 32-bit payload plus a one-bit "simple" marker. When the marker is clear, the payload is the address of the resolved target routine. When the marker is set, the entry describes a trivial field getter or setter, and the payload is a byte offset to add to the object's base address.

A pipeline stage that checks a speculative call target presents a site/type pair on the lookup port. It receives hit, payload and marker in the same cycle, and a registered copy one cycle later. The software dispatch routine that resolves a missing pair inserts the result through the write port. A write to a key that is already present updates that entry in place. A write of a new key fills the lowest-numbered free entry, or, when the table is full, replaces the entry named by a round-robin pointer. A flush input empties the table in one cycle.

Top module: `site_type_resolver`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses. On a miss, hit, marker and payload all read 0, both on the combinational outputs and on the registered outputs.
- R2: While `lk_valid_i` is 1, the combinational outputs report a hit when a valid entry has the same PC and the same type as the probe, together with that entry's payload and marker, in the same cycle. While `lk_valid_i` is 0, hit, marker and payload read 0.
- R3: The registered outputs hold, one clock edge later, the values the combinational outputs had in the previous cycle.
- R4: Both fields of the key must match. A probe with the right PC and a different type misses, and so does a probe with the right type and a different PC.
- R5: Writing a key that is already present replaces that entry's payload and marker in place and uses no new entry, so the table never holds two entries with the same key.
- R6: A write of a key that is not present, while some entry is invalid, goes into the lowest-numbered invalid entry.
- R7: A write of a new key while all 16 entries are valid replaces the entry at the round-robin pointer. The pointer is 0 after reset and after a flush. It advances by one after each such replacement and wraps from 15 to 0.
- R8: A cycle with `flush_i` at 1 invalidates every entry and resets the pointer to 0. A write presented in the same cycle is dropped.
- R9: A lookup and a write of the same key in the same cycle: the lookup returns the contents from before the write (a miss for a new key, the old payload for an existing key). The new contents are visible from the next cycle on.
- R10: The marker bit and all 32 payload bits are stored and returned unchanged, whether the marker is 0 or 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| flush_i | input | 1 | Invalidate all entries this cycle |
| lk_valid_i | input | 1 | Lookup request qualifier |
| lk_pc_i | input | 32 | Call-site PC of the probe |
| lk_type_i | input | 16 | Object type ID of the probe |
| lk_hit_o | output | 1 | Same-cycle hit |
| lk_payload_o | output | 32 | Same-cycle payload (0 on miss) |
| lk_simple_o | output | 1 | Same-cycle simple marker (0 on miss) |
| lk_hit_q_o | output | 1 | Registered hit, one cycle later |
| lk_payload_q_o | output | 32 | Registered payload |
| lk_simple_q_o | output | 1 | Registered simple marker |
| wr_en_i | input | 1 | Insert or update request |
| wr_pc_i | input | 32 | Call-site PC of the entry to write |
| wr_type_i | input | 16 | Type ID of the entry to write |
| wr_payload_i | input | 32 | Target address or field offset |
| wr_simple_i | input | 1 | Marker: payload is a field offset |

## Verification
Combinational lookup results are due in the cycle the probe is driven. The bench drives each probe just after a falling edge and samples one time unit later, before the next rising edge. The registered copies are due after exactly one rising edge, so the bench samples them one time unit after that edge. A write becomes visible one rising edge after it is presented, and every check that depends on it is made only after that edge. Same-cycle write and lookup pairs are sampled before the edge, which captures the old contents. Replacement order and pointer reset are observed through the keys that go missing after each write, and those keys are compared against a bench model built from the requirements.

// File: rtl/srt_pkg.sv
// Package: shared constants and types for the type-keyed resolution table.
// Assumes: consumers size their ports from the top-level parameters.
package srt_pkg;

    // Source of the slot chosen for a write
    typedef enum logic [1:0] {
        SLOT_MATCH = 2'd0,
        SLOT_FREE  = 2'd1,
        SLOT_EVICT = 2'd2
    } slot_src_e;

endpackage

// File: rtl/srt_match.sv
// Module: srt_match
// Compares one probe key against every stored key and returns a per-entry
// match vector qualified by the entry valid bits and a request enable.
// Assumes: keys are unique among valid entries.
module srt_match #(
    parameter int N     = 16,
    parameter int KEY_W = 48
) (
    input  logic                      en,
    input  logic [KEY_W-1:0]          probe,
    input  logic [N-1:0][KEY_W-1:0]   keys,
    input  logic [N-1:0]              valid,
    output logic [N-1:0]              hit_vec
);

    // One comparator per entry
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_vec[g] = en && valid[g] && (keys[g] == probe);
    end

endmodule

// File: rtl/srt_alloc.sv
// Module: srt_alloc
// Chooses the slot for a write: the matching entry if the key exists,
// else the lowest invalid entry, else the round-robin victim. Holds the
// round-robin pointer.
// Assumes: wr_en is already gated by flush at the top.
module srt_alloc
    import srt_pkg::*;
#(
    parameter int N     = 16,
    localparam int IW   = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             wr_en,
    input  logic [N-1:0]     wr_hit_vec,
    input  logic [N-1:0]     valid,
    output logic [IW-1:0]    wr_idx,
    output slot_src_e        src
);

    logic [IW-1:0] ptr_q;
    logic [IW-1:0] free_idx;
    logic [IW-1:0] match_idx;
    logic          any_free;
    logic          any_match;

    // Lowest-index invalid entry
    always_comb begin
        free_idx = '0;
        any_free = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                free_idx = IW'(i);
                any_free = 1'b1;
            end
        end
    end

    // Index of the matching entry (at most one)
    always_comb begin
        match_idx = '0;
        any_match = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (wr_hit_vec[i]) begin
                match_idx = match_idx | IW'(i);
                any_match = 1'b1;
            end
        end
    end

    // Slot selection priority: match, free, victim
    always_comb begin
        if (any_match) begin
            src    = SLOT_MATCH;
            wr_idx = match_idx;
        end else if (any_free) begin
            src    = SLOT_FREE;
            wr_idx = free_idx;
        end else begin
            src    = SLOT_EVICT;
            wr_idx = ptr_q;
        end
    end

    // Round-robin victim pointer
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            ptr_q <= '0;
        end else if (wr_en && src == SLOT_EVICT) begin
            ptr_q <= (ptr_q == IW'(N - 1)) ? '0 : ptr_q + 1'b1;
        end
    end

    // R7
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && !(wr_en && src == SLOT_EVICT)) |=> $stable(ptr_q));

    // R8
    ptr_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> ptr_q == '0);

    // R6
    free_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && src == SLOT_FREE) |-> !valid[wr_idx]);

endmodule

// File: rtl/srt_store.sv
// Module: srt_store
// Entry storage: key, data and valid bit per entry. Writes one entry per
// cycle at wr_idx; flush clears every valid bit.
// Assumes: wr_en is dropped by the caller while flush is high.
module srt_store #(
    parameter int N      = 16,
    parameter int KEY_W  = 48,
    parameter int DATA_W = 33,
    localparam int IW    = $clog2(N)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      flush,
    input  logic                      wr_en,
    input  logic [IW-1:0]             wr_idx,
    input  logic [KEY_W-1:0]          wr_key,
    input  logic [DATA_W-1:0]         wr_data,
    output logic [N-1:0][KEY_W-1:0]   keys,
    output logic [N-1:0][DATA_W-1:0]  data,
    output logic [N-1:0]              valid
);

    // Valid bits: reset and flush clear, write sets
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            valid <= '0;
        end else if (wr_en) begin
            valid[wr_idx] <= 1'b1;
        end
    end

    // Key and data storage, updated on write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            keys <= '0;
            data <= '0;
        end else if (wr_en) begin
            keys[wr_idx] <= wr_key;
            data[wr_idx] <= wr_data;
        end
    end

    // R8
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> valid == '0);

    // R5
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !flush) |=> (valid[$past(wr_idx)] &&
                               keys[$past(wr_idx)] == $past(wr_key) &&
                               data[$past(wr_idx)] == $past(wr_data)));

endmodule

// File: rtl/site_type_resolver.sv
// Module: site_type_resolver (top)
// Fully associative table keyed by {call-site PC, type ID}, returning a
// payload and a simple-accessor marker. Lookup is combinational with a
// registered copy; writes update in place or allocate free/round-robin.
// Assumes: one lookup and one write port; flush overrides a same-cycle write.
module site_type_resolver
    import srt_pkg::*;
#(
    parameter int ENTRIES   = 16,
    parameter int PC_W      = 32,
    parameter int TYPE_W    = 16,
    parameter int PAYLOAD_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 flush_i,
    input  logic                 lk_valid_i,
    input  logic [PC_W-1:0]      lk_pc_i,
    input  logic [TYPE_W-1:0]    lk_type_i,
    output logic                 lk_hit_o,
    output logic [PAYLOAD_W-1:0] lk_payload_o,
    output logic                 lk_simple_o,
    output logic                 lk_hit_q_o,
    output logic [PAYLOAD_W-1:0] lk_payload_q_o,
    output logic                 lk_simple_q_o,
    input  logic                 wr_en_i,
    input  logic [PC_W-1:0]      wr_pc_i,
    input  logic [TYPE_W-1:0]    wr_type_i,
    input  logic [PAYLOAD_W-1:0] wr_payload_i,
    input  logic                 wr_simple_i
);

    localparam int KEY_W  = PC_W + TYPE_W;
    localparam int DATA_W = PAYLOAD_W + 1;
    localparam int IW     = $clog2(ENTRIES);

    logic [ENTRIES-1:0][KEY_W-1:0]  keys;
    logic [ENTRIES-1:0][DATA_W-1:0] data;
    logic [ENTRIES-1:0]             valid;
    logic [ENTRIES-1:0]             lk_vec;
    logic [ENTRIES-1:0]             wr_vec;
    logic [DATA_W-1:0]              lk_data;
    logic [IW-1:0]                  wr_idx;
    slot_src_e                      wr_src;
    logic                           wr_go;
    logic                           past_ok;

    // A flush drops any same-cycle write
    assign wr_go = wr_en_i && !flush_i;

    srt_match #(.N(ENTRIES), .KEY_W(KEY_W)) u_lk_match (
        .en      (lk_valid_i),
        .probe   ({lk_pc_i, lk_type_i}),
        .keys    (keys),
        .valid   (valid),
        .hit_vec (lk_vec)
    );

    srt_match #(.N(ENTRIES), .KEY_W(KEY_W)) u_wr_match (
        .en      (wr_en_i),
        .probe   ({wr_pc_i, wr_type_i}),
        .keys    (keys),
        .valid   (valid),
        .hit_vec (wr_vec)
    );

    srt_alloc #(.N(ENTRIES)) u_alloc (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush_i),
        .wr_en      (wr_go),
        .wr_hit_vec (wr_vec),
        .valid      (valid),
        .wr_idx     (wr_idx),
        .src        (wr_src)
    );

    srt_store #(.N(ENTRIES), .KEY_W(KEY_W), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush_i),
        .wr_en   (wr_go),
        .wr_idx  (wr_idx),
        .wr_key  ({wr_pc_i, wr_type_i}),
        .wr_data ({wr_simple_i, wr_payload_i}),
        .keys    (keys),
        .data    (data),
        .valid   (valid)
    );

    // One-hot read mux: OR of the data of the matching entry
    always_comb begin
        lk_data = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            lk_data = lk_data | (data[i] & {DATA_W{lk_vec[i]}});
        end
    end

    assign lk_hit_o     = |lk_vec;
    assign lk_simple_o  = lk_data[DATA_W-1];
    assign lk_payload_o = lk_data[PAYLOAD_W-1:0];

    // Registered copy of the lookup result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_hit_q_o     <= 1'b0;
            lk_simple_q_o  <= 1'b0;
            lk_payload_q_o <= '0;
        end else begin
            lk_hit_q_o     <= lk_hit_o;
            lk_simple_q_o  <= lk_simple_o;
            lk_payload_q_o <= lk_payload_o;
        end
    end

    // Marks that one cycle out of reset has passed, for $past checks
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R5
    no_dup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_vec) && $onehot0(wr_vec));

    // R3
    reg_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |=> (lk_hit_q_o == $past(lk_hit_o) &&
                     lk_payload_q_o == $past(lk_payload_o) &&
                     lk_simple_q_o == $past(lk_simple_o)));

    // R1
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit_o |-> (lk_payload_o == '0 && !lk_simple_o));

    // R2
    idle_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid_i |-> !lk_hit_o);

endmodule

// File: tb/sim_site_type_resolver.sv
// Directed bench for site_type_resolver with a requirement-level model.
module sim_site_type_resolver;

    localparam int CLK_PERIOD = 10;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush_i = 1'b0;
    logic        lk_valid_i = 1'b0;
    logic [31:0] lk_pc_i = '0;
    logic [15:0] lk_type_i = '0;
    logic        lk_hit_o, lk_simple_o, lk_hit_q_o, lk_simple_q_o;
    logic [31:0] lk_payload_o, lk_payload_q_o;
    logic        wr_en_i = 1'b0;
    logic [31:0] wr_pc_i = '0;
    logic [15:0] wr_type_i = '0;
    logic [31:0] wr_payload_i = '0;
    logic        wr_simple_i = 1'b0;

    int checks = 0;
    int fails  = 0;

    // Bench model of the table, built from R5-R8
    logic [31:0] m_pc   [N];
    logic [15:0] m_type [N];
    logic [31:0] m_pay  [N];
    logic        m_simp [N];
    logic        m_val  [N];
    int          m_ptr;

    always #(CLK_PERIOD / 2) clk = ~clk;

    site_type_resolver u0 (
        .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
        .lk_valid_i(lk_valid_i), .lk_pc_i(lk_pc_i), .lk_type_i(lk_type_i),
        .lk_hit_o(lk_hit_o), .lk_payload_o(lk_payload_o), .lk_simple_o(lk_simple_o),
        .lk_hit_q_o(lk_hit_q_o), .lk_payload_q_o(lk_payload_q_o),
        .lk_simple_q_o(lk_simple_q_o),
        .wr_en_i(wr_en_i), .wr_pc_i(wr_pc_i), .wr_type_i(wr_type_i),
        .wr_payload_i(wr_payload_i), .wr_simple_i(wr_simple_i)
    );

    function automatic logic [31:0] kpc(int i);
        return 32'h4000_0000 + 32'(i) * 32'h40;
    endfunction

    function automatic logic [15:0] kty(int i);
        return 16'h0100 + 16'(i);
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [33:0] act, input logic [33:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < N; i++) m_val[i] = 1'b0;
        m_ptr = 0;
    endtask

    task automatic model_write(input logic [31:0] pc, input logic [15:0] ty,
                               input logic [31:0] pay, input logic simp);
        int slot = -1;
        for (int i = 0; i < N; i++)
            if (slot < 0 && m_val[i] && m_pc[i] == pc && m_type[i] == ty) slot = i;
        if (slot < 0)
            for (int i = 0; i < N; i++)
                if (slot < 0 && !m_val[i]) slot = i;
        if (slot < 0) begin
            slot  = m_ptr;
            m_ptr = (m_ptr + 1) % N;
        end
        m_val[slot] = 1'b1; m_pc[slot] = pc; m_type[slot] = ty;
        m_pay[slot] = pay;  m_simp[slot] = simp;
    endtask

    function automatic logic [33:0] model_read(input logic [31:0] pc, input logic [15:0] ty);
        for (int i = 0; i < N; i++)
            if (m_val[i] && m_pc[i] == pc && m_type[i] == ty)
                return {1'b1, m_simp[i], m_pay[i]};
        return '0;
    endfunction

    task automatic do_write(input logic [31:0] pc, input logic [15:0] ty,
                            input logic [31:0] pay, input logic simp);
        @(negedge clk);
        wr_en_i = 1'b1; wr_pc_i = pc; wr_type_i = ty;
        wr_payload_i = pay; wr_simple_i = simp;
        @(posedge clk); #1;
        wr_en_i = 1'b0;
        model_write(pc, ty, pay, simp);
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush_i = 1'b1;
        @(posedge clk); #1;
        flush_i = 1'b0;
        model_clear();
    endtask

    // Probe a key; check same-cycle (R2) and registered (R3) results
    task automatic probe(input logic [31:0] pc, input logic [15:0] ty, input string tag);
        logic [33:0] exp;
        @(negedge clk);
        lk_valid_i = 1'b1; lk_pc_i = pc; lk_type_i = ty;
        #1;
        exp = model_read(pc, ty);
        check({lk_hit_o, lk_simple_o, lk_payload_o} == exp, {tag, " R2 comb"},
              {lk_hit_o, lk_simple_o, lk_payload_o}, exp);
        @(posedge clk); #1;
        lk_valid_i = 1'b0;
        check({lk_hit_q_o, lk_simple_q_o, lk_payload_q_o} == exp, {tag, " R3 reg"},
              {lk_hit_q_o, lk_simple_q_o, lk_payload_q_o}, exp);
    endtask

    task automatic t_reset();
        probe(kpc(0), kty(0), "R1 reset miss");
        probe(32'h0, 16'h0, "R1 reset zero key");
    endtask

    task automatic t_basic();
        logic [33:0] act;
        do_write(kpc(1), kty(1), 32'h8000_1234, 1'b0);
        do_write(kpc(2), kty(2), 32'h0000_0018, 1'b1);
        do_write(kpc(3), kty(3), 32'hFFFF_FFFF, 1'b1);
        probe(kpc(1), kty(1), "R2 target entry");
        probe(kpc(2), kty(2), "R10 simple offset");
        probe(kpc(3), kty(3), "R10 all ones");
        // R2: qualifier low gives no hit even for a stored key
        @(negedge clk);
        lk_valid_i = 1'b0; lk_pc_i = kpc(1); lk_type_i = kty(1);
        #1;
        act = {lk_hit_o, lk_simple_o, lk_payload_o};
        check(act == '0, "R2 lookup idle", act, '0);
    endtask

    task automatic t_key();
        probe(kpc(1), kty(2), "R4 pc ok type wrong");
        probe(kpc(2), kty(1), "R4 type ok pc wrong");
        probe(kpc(1), kty(1), "R4 both match");
    endtask

    task automatic t_overwrite();
        do_flush();
        do_write(kpc(0), kty(0), 32'hAAAA_0000, 1'b0);
        do_write(kpc(0), kty(0), 32'h0000_0024, 1'b1);
        probe(kpc(0), kty(0), "R5 updated in place");
        for (int i = 1; i < N; i++) do_write(kpc(i), kty(i), 32'h1000 + 32'(i), 1'b0);
        probe(kpc(N - 1), kty(N - 1), "R5 sixteenth key fits");
        probe(kpc(0), kty(0), "R5 first key still held");
        do_write(kpc(40), kty(40), 32'h5555, 1'b0);
        probe(kpc(0), kty(0), "R5 slot0 evicted once full");
        probe(kpc(1), kty(1), "R5 slot1 retained");
    endtask

    task automatic t_evict();
        do_flush();
        for (int i = 0; i < N; i++) do_write(kpc(i), kty(i), 32'h2000 + 32'(i), 1'b0);
        for (int i = 0; i < N; i++) probe(kpc(i), kty(i), "R6 fill");
        do_write(kpc(20), kty(20), 32'h3000, 1'b0);
        probe(kpc(0), kty(0), "R7 first victim slot0");
        probe(kpc(1), kty(1), "R7 slot1 kept");
        do_write(kpc(21), kty(21), 32'h3001, 1'b0);
        probe(kpc(1), kty(1), "R7 second victim slot1");
        probe(kpc(2), kty(2), "R7 slot2 kept");
        for (int i = 22; i < 36; i++) do_write(kpc(i), kty(i), 32'h3000 + 32'(i), 1'b0);
        probe(kpc(15), kty(15), "R7 slot15 replaced");
        probe(kpc(20), kty(20), "R7 before wrap");
        do_write(kpc(36), kty(36), 32'h3036, 1'b0);
        probe(kpc(20), kty(20), "R7 wrap to slot0");
        probe(kpc(21), kty(21), "R7 slot1 after wrap");
    endtask

    task automatic t_flush();
        // pointer is at 1 here; flush with a same-cycle write
        @(negedge clk);
        flush_i = 1'b1;
        wr_en_i = 1'b1; wr_pc_i = kpc(50); wr_type_i = kty(50);
        wr_payload_i = 32'h7777; wr_simple_i = 1'b0;
        @(posedge clk); #1;
        flush_i = 1'b0; wr_en_i = 1'b0;
        model_clear();
        probe(kpc(50), kty(50), "R8 write dropped");
        probe(kpc(21), kty(21), "R8 entry cleared");
        probe(kpc(36), kty(36), "R8 entry cleared 2");
        for (int i = 0; i < N; i++) do_write(kpc(60 + i), kty(60 + i), 32'(i), 1'b1);
        do_write(kpc(90), kty(90), 32'h9090, 1'b0);
        probe(kpc(60), kty(60), "R8 pointer back to 0");
        probe(kpc(61), kty(61), "R8 slot1 kept");
    endtask

    task automatic t_same_cycle();
        logic [33:0] act;
        logic [33:0] exp;
        do_flush();
        do_write(kpc(5), kty(5), 32'h0000_1111, 1'b0);
        // existing key: lookup sees old payload
        @(negedge clk);
        wr_en_i = 1'b1; wr_pc_i = kpc(5); wr_type_i = kty(5);
        wr_payload_i = 32'h0000_2222; wr_simple_i = 1'b1;
        lk_valid_i = 1'b1; lk_pc_i = kpc(5); lk_type_i = kty(5);
        #1;
        exp = {1'b1, 1'b0, 32'h0000_1111};
        act = {lk_hit_o, lk_simple_o, lk_payload_o};
        check(act == exp, "R9 old contents comb", act, exp);
        @(posedge clk); #1;
        wr_en_i = 1'b0; lk_valid_i = 1'b0;
        act = {lk_hit_q_o, lk_simple_q_o, lk_payload_q_o};
        check(act == exp, "R9 old contents reg", act, exp);
        model_write(kpc(5), kty(5), 32'h0000_2222, 1'b1);
        probe(kpc(5), kty(5), "R9 new contents next cycle");
        // new key: same-cycle lookup misses
        @(negedge clk);
        wr_en_i = 1'b1; wr_pc_i = kpc(6); wr_type_i = kty(6);
        wr_payload_i = 32'h0000_3333; wr_simple_i = 1'b0;
        lk_valid_i = 1'b1; lk_pc_i = kpc(6); lk_type_i = kty(6);
        #1;
        act = {lk_hit_o, lk_simple_o, lk_payload_o};
        check(act == '0, "R9 new key miss", act, '0);
        @(posedge clk); #1;
        wr_en_i = 1'b0; lk_valid_i = 1'b0;
        model_write(kpc(6), kty(6), 32'h0000_3333, 1'b0);
        probe(kpc(6), kty(6), "R9 new key visible");
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        model_clear();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_basic();
        t_key();
        t_overwrite();
        t_evict();
        t_flush();
        t_same_cycle();
        repeat (2) @(posedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule